// File: doc/BRIEF.md
# FIR Multiply-Accumulate Engine

This block works out one output sample of a finite impulse response filter, y = sum over i of x[j-i]*a[i], for a run-time tap count n. Coefficients and samples live in two separate synchronous memory banks. The engine reads both banks in the same cycle, so a coefficient fetch and a sample fetch always travel together. The coefficient address counts up from 0 and the sample address counts down from n-1. Operand fetch for the next tap overlaps the multiply-accumulate of the current one. A hardware loop counter steps the taps with no extra cycles between them.

The engine is started with a single-cycle `start` pulse that carries the tap count. It returns the signed sum on `result` along with a one-cycle `done` pulse. Both memory read ports have a fixed latency of one cycle. Data must be valid on the clock edge after the edge that sampled the enable. The ports have no back-pressure: the engine never waits on a memory, and a memory must never stall. `busy` is a plain status pin that is high from the accepted start to the cycle of `done`.

Top module: `fir_mac_engine`

## Requirements
- R1: While `rst_n` is low and right after reset, `busy`, `done`, both read enables and `result` are all 0.
- R2: A start is accepted when `start` is high, `busy` is low and `taps` is non-zero on a clock edge. On that edge `result` clears to 0 and `busy` rises.
- R3: In the first cycle after the accepting edge, both read enables are high, with coefficient address 0 and sample address n-1.
- R4: After each read, the coefficient address rises by one and the sample address falls by one. Reads run in n consecutive cycles, and there is no read after the n-th.
- R5: The coefficient and sample read enables are always high in the same cycles.
- R6: When `done` is high, `result` equals the sum over i from 0 to n-1 of coef[i]*sample[n-1-i]. Both operands are 16-bit two's complement read one cycle after their address, and the sum is held in 40-bit two's complement.
- R7: `done` is high for exactly one cycle. It is set by the (n+1)-th clock edge after the accepting edge, and `busy` falls on that same edge.
- R8: Outside a run, `result` keeps its value until the next accepted start.
- R9: A `start` that arrives while `busy` is high is ignored. The run in flight keeps its tap count, its read pattern and its timing.
- R10: A `start` with `taps` equal to 0 is ignored. `busy` stays low and `result` is unchanged.
- R11: With 63 taps of -32768 times -32768, the result is exact, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, one cycle |
| taps | input | AW (6) | Tap count n, 1 to 2^AW-1 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when `result` is final |
| coef_rd_en | output | 1 | Coefficient bank read enable |
| coef_addr | output | AW (6) | Coefficient bank address |
| coef_rd_data | input | DW (16) | Coefficient read data, one cycle latency |
| samp_rd_en | output | 1 | Sample bank read enable |
| samp_addr | output | AW (6) | Sample bank address |
| samp_rd_data | input | DW (16) | Sample read data, one cycle latency |
| result | output | ACCW (40) | Signed accumulated sum |

## Verification
Suppose the loop counter is off by one. Then `done` shows up a cycle early or late, and the reads at the ports number n±1, so the error is visible within the run it hits. If an address register steps the wrong way or starts from the wrong value, the very first or second read address shows it, and the products and `result` go wrong at `done`. If the accumulator is not cleared, the previous result leaks into the next run. That shows at the next `done`, and at once on `result` in the cycle after the accepting edge.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOOP  = 2'd2
  } fir_state_e;
endpackage

// File: rtl/fir_loop_ctl.sv
module fir_loop_ctl
  import fir_mac_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] taps,
  output logic          accept,
  output logic          rd_en,
  output logic          mac_en,
  output logic          busy,
  output logic          done
);
  fir_state_e    st;
  logic [AW-1:0] cnt;
  logic          last;

  assign accept = start && (st == ST_IDLE) && (taps != '0);
  assign last   = (st == ST_LOOP) && (cnt == AW'(1));
  assign rd_en  = (st == ST_FETCH) || ((st == ST_LOOP) && (cnt > AW'(1)));
  assign mac_en = (st == ST_LOOP);
  assign busy   = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      unique case (st)
        ST_IDLE: if (accept) begin
          st  <= ST_FETCH;
          cnt <= taps;
        end
        ST_FETCH: st <= ST_LOOP;
        ST_LOOP: begin
          cnt <= cnt - AW'(1);
          if (last) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOOP && cnt > AW'(1)) |=> (st == ST_LOOP && cnt == $past(cnt) - AW'(1)));

  // R10
  zero_taps_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && taps == '0 && st == ST_IDLE) |=> (st == ST_IDLE));
endmodule

// File: rtl/fir_agu.sv
module fir_agu #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] taps,
  input  logic          step,
  output logic [AW-1:0] coef_addr,
  output logic [AW-1:0] samp_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_addr <= '0;
      samp_addr <= '0;
    end else if (load) begin
      coef_addr <= '0;
      samp_addr <= taps - AW'(1);
    end else if (step) begin
      coef_addr <= coef_addr + AW'(1);
      samp_addr <= samp_addr - AW'(1);
    end
  end

  // R4
  coef_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && $past(step)) |-> (coef_addr == $past(coef_addr) + AW'(1)));

  // R4
  samp_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && $past(step)) |-> (samp_addr == $past(samp_addr) - AW'(1)));
endmodule

// File: rtl/fir_mac_dp.sv
module fir_mac_dp #(
  parameter int DW   = 16,
  parameter int ACCW = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   en,
  input  logic signed [DW-1:0]   op_a,
  input  logic signed [DW-1:0]   op_b,
  output logic signed [ACCW-1:0] acc
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;

  assign prod = op_a * op_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (en)  acc <= acc + ACCW'(prod);
  end

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(acc));
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine #(
  parameter int DW   = 16,
  parameter int AW   = 6,
  parameter int ACCW = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [AW-1:0]          taps,
  output logic                   busy,
  output logic                   done,
  output logic                   coef_rd_en,
  output logic [AW-1:0]          coef_addr,
  input  logic signed [DW-1:0]   coef_rd_data,
  output logic                   samp_rd_en,
  output logic [AW-1:0]          samp_addr,
  input  logic signed [DW-1:0]   samp_rd_data,
  output logic signed [ACCW-1:0] result
);
  logic accept;
  logic rd_en;
  logic mac_en;

  fir_loop_ctl #(.AW(AW)) ctl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .taps   (taps),
    .accept (accept),
    .rd_en  (rd_en),
    .mac_en (mac_en),
    .busy   (busy),
    .done   (done)
  );

  fir_agu #(.AW(AW)) agu_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .taps      (taps),
    .step      (rd_en),
    .coef_addr (coef_addr),
    .samp_addr (samp_addr)
  );

  fir_mac_dp #(.DW(DW), .ACCW(ACCW)) dp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (mac_en),
    .op_a  (coef_rd_data),
    .op_b  (samp_rd_data),
    .acc   (result)
  );

  assign coef_rd_en = rd_en;
  assign samp_rd_en = rd_en;

  // R2
  acc_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (result == '0));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
endmodule

// File: tb/fir_mac_engine_tb.sv
`timescale 1ns/1ps
module fir_mac_engine_tb_top;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int ACCW = 40;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic [5:0] n;
    logic [2:0] pat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{n: 6'd1,  pat: 3'd3}, '{n: 6'd2,  pat: 3'd0}, '{n: 6'd5,  pat: 3'd1},
    '{n: 6'd8,  pat: 3'd4}, '{n: 6'd16, pat: 3'd0}, '{n: 6'd63, pat: 3'd2},
    '{n: 6'd63, pat: 3'd1}, '{n: 6'd3,  pat: 3'd4}, '{n: 6'd7,  pat: 3'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] taps = '0;
  logic busy, done, coef_rd_en, samp_rd_en;
  logic [AW-1:0] coef_addr, samp_addr;
  logic signed [DW-1:0] coef_q, samp_q;
  logic signed [ACCW-1:0] result;

  logic signed [DW-1:0] cmem [DEPTH];
  logic signed [DW-1:0] smem [DEPTH];

  int checks = 0;
  int fails = 0;
  bit mon_on = 1'b0;
  int rd_idx = 0;
  int cur_n = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fir_mac_engine #(.DW(DW), .AW(AW), .ACCW(ACCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .taps(taps),
    .busy(busy), .done(done),
    .coef_rd_en(coef_rd_en), .coef_addr(coef_addr), .coef_rd_data(coef_q),
    .samp_rd_en(samp_rd_en), .samp_addr(samp_addr), .samp_rd_data(samp_q),
    .result(result)
  );

  always @(posedge clk) begin
    if (coef_rd_en) coef_q <= cmem[coef_addr];
    if (samp_rd_en) samp_q <= smem[samp_addr];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Read-port monitor: R3, R4, R5
  always @(negedge clk) begin
    if (rst_n) begin
      if (coef_rd_en != samp_rd_en)
        chk(1'b0, "R5 enables differ", longint'(coef_rd_en), longint'(samp_rd_en));
      if (mon_on && coef_rd_en) begin
        chk(int'(coef_addr) == rd_idx, "R3/R4 coef addr", longint'(coef_addr), longint'(rd_idx));
        chk(int'(samp_addr) == cur_n - 1 - rd_idx, "R3/R4 samp addr",
            longint'(samp_addr), longint'(cur_n - 1 - rd_idx));
        rd_idx++;
      end
    end
  end

  function automatic logic signed [DW-1:0] pval(input int pat, input int i, input bit is_c);
    int v;
    case (pat)
      0: v = is_c ? (i + 1) : (100 - 3 * i);
      1: v = ((i % 2) == 0) ? (is_c ? 32767 : -32768) : (is_c ? -32768 : 32767);
      2: v = -32768;
      3: v = is_c ? ((i == 0) ? 1000 : 0) : (i * 7 - 20);
      default: v = ((i * 2654435 + (is_c ? 12345 : 777)) % 65536) - 32768;
    endcase
    return DW'(v);
  endfunction

  function automatic longint expected_sum(input int n);
    longint s = 0;
    for (int i = 0; i < n; i++) s += longint'(cmem[i]) * longint'(smem[n - 1 - i]);
    return s;
  endfunction

  // Drive one run; optional intruding start at cycle 'poke_at' (0 = none)
  task automatic run(input int n, input int poke_at, input string tag);
    int edges = 0;
    bit seen = 1'b0;
    longint exp = expected_sum(n);
    cur_n = n;
    rd_idx = 0;
    mon_on = 1'b1;
    @(negedge clk);
    start = 1'b1; taps = AW'(n);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; taps = '0;
    // R2: result cleared and busy high after accepting edge
    chk(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
    chk(result == '0, "R2 result cleared", longint'(result), 0);
    edges = 0;
    while (!seen && edges < n + 10) begin
      if (edges + 1 == poke_at) begin start = 1'b1; taps = AW'(2); end
      @(posedge clk);
      edges++;
      @(negedge clk);
      start = 1'b0; taps = '0;
      if (done) seen = 1'b1;
    end
    // R7 / R9: done timing
    chk(seen && edges == n + 1, {"R7 done timing ", tag}, longint'(edges), longint'(n + 1));
    chk(busy == 1'b0, "R7 busy low with done", longint'(busy), 0);
    // R6 / R11 value
    chk(longint'(result) == exp, {"R6 result ", tag}, longint'(result), exp);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", longint'(done), 0);
    // R4: exactly n reads
    chk(rd_idx == n, "R4 read count", longint'(rd_idx), longint'(n));
    mon_on = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    longint hold;
    for (int i = 0; i < DEPTH; i++) begin cmem[i] = '0; smem[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done in reset", longint'({busy, done}), 0);
    chk(coef_rd_en == 1'b0 && samp_rd_en == 1'b0, "R1 read enables in reset",
        longint'({coef_rd_en, samp_rd_en}), 0);
    chk(result == '0, "R1 result in reset", longint'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && result == '0, "R1 after reset", longint'(busy), 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < DEPTH; i++) begin
        cmem[i] = pval(int'(VECS[v].pat), i, 1'b1);
        smem[i] = pval(int'(VECS[v].pat), i, 1'b0);
      end
      run(int'(VECS[v].n), 0, (VECS[v].pat == 3'd2) ? "R11 max negative" : "vector");
    end

    // R8: result holds while idle
    hold = longint'(result);
    repeat (5) @(negedge clk);
    chk(longint'(result) == hold, "R8 result held idle", longint'(result), hold);

    // R10: zero taps start ignored
    start = 1'b1; taps = '0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R10 zero taps busy", longint'(busy), 0);
    @(negedge clk);
    chk(longint'(result) == hold, "R10 zero taps result", longint'(result), hold);
    chk(coef_rd_en == 1'b0, "R10 zero taps no read", longint'(coef_rd_en), 0);

    // R9: start during busy ignored
    for (int i = 0; i < DEPTH; i++) begin
      cmem[i] = pval(0, i, 1'b1);
      smem[i] = pval(4, i, 1'b0);
    end
    run(10, 4, "R9 busy start ignored");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule